// File: doc/BRIEF.md
# Signed 64-bit Hardware Divider

A register-mapped signed integer divider. Software writes a numerator and a denominator, each held as a 64-bit value split across four 16-bit halfword registers with the least significant half at the lowest address. It also writes a two-bit operand-width mode into a control register. Every write to the control register or to any operand half starts a new division. A busy flag marks the computation in flight.

The quotient is computed by a restoring divider that produces one bit per clock on operand magnitudes. A final cycle then applies the signs. When busy clears, the quotient and remainder registers hold the result and an error flag reports whether a special case was hit. Division by zero and the most-negative-by-minus-one overflow each give a defined result rather than an undefined one.

The register port is a plain single-cycle write strobe with an asynchronous read mux. A write is always accepted, so the port has no back-pressure. A write that arrives while a division is running abandons that division and starts over on the new operand values.

Top module: `signed_divider`

## Requirements
- R1: After reset, every register reads 0: the control register, with mode 0, error flag clear and busy clear, as well as all operand and result halves.
- R2: Halfword address map. Address 0 is control: mode in bits [1:0], error flag in bit 14, busy in bit 15. Addresses 1-4 hold the numerator and 5-8 the denominator. Addresses 9-12 hold the quotient and 13-16 the remainder. Within each group the lowest address is bits [15:0]. Writes to addresses 9 and above change nothing and start nothing, and unmapped addresses read 0.
- R3: Mode 0 sign-extends bits [31:0] of both operands. Modes 1 and 3 use the full 64-bit numerator and sign-extend bits [31:0] of the denominator. Mode 2 uses both operands at full 64 bits.
- R4: For a nonzero extended denominator, outside the overflow case, the quotient is truncated toward zero and the remainder carries the sign of the numerator. The error flag is cleared.
- R5: If the extended denominator is zero, the error flag is set and the remainder receives the extended numerator. The quotient is 1 if that numerator is negative and 0 otherwise.
- R6: If the extended numerator is the most negative 64-bit value and the extended denominator is -1, the error flag is set and the quotient receives the numerator. The remainder keeps its previous value.
- R7: A write to address 0-8 sets busy on that clock edge. Busy reads 1 for exactly W+2 clock cycles, where W is the operand width. The results and the error flag are updated on the edge where busy clears.
- R8: A write to address 0-8 during a running division abandons it, and the abandoned result is never stored. Busy stays set for W+2 cycles counted from the latest write, and the stored result reflects the latest operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Halfword write address |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Halfword read address |
| rd_data | output | REG_W | Read data for rd_addr, combinational |

## Verification
The bench builds the divider with its defaults: W = 64, 16-bit registers and a 5-bit address. The bench's 64-bit integer reference can then be compared against every mode directly. These defaults bring within reach the full-width corner where the numerator is the most negative value, along with mode 1 and mode 3 denominators whose low 32 bits sign-extend to -1. The 66-cycle busy window is timed exactly. This includes a restart late in a running division, to show that the abandoned result never lands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } core_st_e;

  localparam logic [1:0] MODE_HALF_BOTH = 2'd0;
  localparam logic [1:0] MODE_FULL_BOTH = 2'd2;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 64
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] num_raw,
  input  logic [W-1:0] den_raw,
  output logic [W-1:0] num_x,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         div_zero,
  output logic         ovf
);
  import div_pkg::*;
  localparam int HW = W / 2;

  logic [W-1:0] num_short, den_short, den_x;

  always_comb begin
    num_short = {{HW{num_raw[HW-1]}}, num_raw[HW-1:0]};
    den_short = {{HW{den_raw[HW-1]}}, den_raw[HW-1:0]};
    num_x     = (mode == MODE_HALF_BOTH) ? num_short : num_raw;
    den_x     = (mode == MODE_FULL_BOTH) ? den_raw : den_short;
    num_mag   = num_x[W-1] ? (~num_x + 1'b1) : num_x;
    den_mag   = den_x[W-1] ? (~den_x + 1'b1) : den_x;
    neg_quo   = num_x[W-1] ^ den_x[W-1];
    neg_rem   = num_x[W-1];
    div_zero  = (den_x == '0);
    ovf       = (num_x == {1'b1, {(W-1){1'b0}}}) && (den_x == '1);
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_mag,
  input  logic [W-1:0] den_mag,
  input  logic         neg_quo,
  input  logic         neg_rem,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  import div_pkg::*;
  localparam int CW = $clog2(W + 1);

  core_st_e     st;
  logic [CW-1:0] cnt;
  logic [W-1:0] quo_q, rem_q, den_q;
  logic         nq_q, nr_q;
  logic [W:0]   shifted, diff;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      nq_q  <= 1'b0;
      nr_q  <= 1'b0;
    end else if (start) begin
      st    <= ST_RUN;
      cnt   <= CW'(W);
      quo_q <= num_mag;
      rem_q <= '0;
      den_q <= den_mag;
      nq_q  <= neg_quo;
      nr_q  <= neg_rem;
    end else begin
      case (st)
        ST_RUN: begin
          if (!diff[W]) begin
            rem_q <= diff[W-1:0];
            quo_q <= {quo_q[W-2:0], 1'b1};
          end else begin
            rem_q <= shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= ST_FIX;
        end
        ST_FIX:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done = (st == ST_FIX);
    quo  = nq_q ? (~quo_q + 1'b1) : quo_q;
    rem  = nr_q ? (~rem_q + 1'b1) : rem_q;
  end

  // R7: the iteration counter never runs dry while iterating
  a_r7_run_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (cnt != '0));

  // R4: the magnitude remainder is below the divisor when the run ends
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIX && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/signed_divider.sv
module signed_divider #(
  parameter int W      = 64,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int HALVES   = W / REG_W;
  localparam int NUM_BASE = 1;
  localparam int DEN_BASE = NUM_BASE + HALVES;
  localparam int QUO_BASE = DEN_BASE + HALVES;
  localparam int REM_BASE = QUO_BASE + HALVES;

  logic [1:0]   mode_q;
  logic         err_q, busy_q, start_q;
  logic [W-1:0] num_q, den_q, quo_q, rem_q;

  logic [W-1:0] num_x, num_mag, den_mag, core_quo, core_rem;
  logic         neg_quo, neg_rem, div_zero, ovf, core_done;
  logic         kick, capture;

  div_operand_prep #(.W(W)) u_prep (
    .mode(mode_q), .num_raw(num_q), .den_raw(den_q),
    .num_x(num_x), .num_mag(num_mag), .den_mag(den_mag),
    .neg_quo(neg_quo), .neg_rem(neg_rem),
    .div_zero(div_zero), .ovf(ovf)
  );

  div_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .num_mag(num_mag), .den_mag(den_mag),
    .neg_quo(neg_quo), .neg_rem(neg_rem),
    .done(core_done), .quo(core_quo), .rem(core_rem)
  );

  always_comb begin
    kick    = wr_en && (int'(wr_addr) < QUO_BASE);
    capture = core_done && !start_q && !kick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      num_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
    end else begin
      start_q <= kick;
      if (wr_en) begin
        if (wr_addr == '0) mode_q <= wr_data[1:0];
        for (int h = 0; h < HALVES; h++) begin
          if (int'(wr_addr) == NUM_BASE + h) num_q[h*REG_W +: REG_W] <= wr_data;
          if (int'(wr_addr) == DEN_BASE + h) den_q[h*REG_W +: REG_W] <= wr_data;
        end
      end
      if (kick) begin
        busy_q <= 1'b1;
      end else if (capture) begin
        busy_q <= 1'b0;
        if (div_zero) begin
          err_q <= 1'b1;
          rem_q <= num_x;
          quo_q <= {{(W-1){1'b0}}, num_x[W-1]};
        end else if (ovf) begin
          err_q <= 1'b1;
          quo_q <= num_x;
        end else begin
          err_q <= 1'b0;
          quo_q <= core_quo;
          rem_q <= core_rem;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[1:0]     = mode_q;
      rd_data[REG_W-2] = err_q;
      rd_data[REG_W-1] = busy_q;
    end
    for (int h = 0; h < HALVES; h++) begin
      if (int'(rd_addr) == NUM_BASE + h) rd_data = num_q[h*REG_W +: REG_W];
      if (int'(rd_addr) == DEN_BASE + h) rd_data = den_q[h*REG_W +: REG_W];
      if (int'(rd_addr) == QUO_BASE + h) rd_data = quo_q[h*REG_W +: REG_W];
      if (int'(rd_addr) == REM_BASE + h) rd_data = rem_q[h*REG_W +: REG_W];
    end
  end

  // R7: every starting write raises busy on the next cycle
  a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy_q);

  // R5: a zero divisor leaves the error flag set
  a_r5_zero_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && div_zero) |=> err_q);

  // R6: the overflow case leaves the remainder untouched
  a_r6_ovf_keeps_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && ovf && !div_zero) |=> $stable(rem_q));

  // R8: busy never drops while a restart is pending in the core
  a_r8_no_drop_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> busy_q);
endmodule

// File: tb/signed_divider_test.sv
module signed_divider_test;
  localparam int CLK_P = 10;
  localparam int W = 64;
  localparam int LAT = W + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  signed_divider #(.W(W), .REG_W(16), .ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr64(input logic [4:0] base, input logic [63:0] v);
    for (int h = 0; h < 4; h++) wr(base + 5'(h), v[h*16 +: 16]);
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd64(input logic [4:0] base, output logic [63:0] v);
    logic [15:0] t;
    for (int h = 0; h < 4; h++) begin rd16(base + 5'(h), t); v[h*16 +: 16] = t; end
  endtask

  // count busy cycles starting at the negedge right after the last write edge
  task automatic wait_busy(output int n);
    logic [15:0] c;
    n = 0;
    rd16(5'd0, c);
    while (c[15] && n < 1000) begin
      n++;
      @(negedge clk);
      rd16(5'd0, c);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  task automatic ref_model(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                           input logic [63:0] prev_r,
                           output logic [63:0] q, output logic [63:0] r, output logic e);
    longint ne, de;
    ne = (m == 2'd0) ? longint'(sx(n)) : longint'(n);
    de = (m == 2'd2) ? longint'(d) : longint'(sx(d));
    if (de == 0) begin
      e = 1; r = ne; q = (ne < 0) ? 64'd1 : 64'd0;
    end else if (ne == 64'sh8000_0000_0000_0000 && de == -1) begin
      e = 1; q = ne; r = prev_r;
    end else begin
      e = 0; q = ne / de; r = ne % de;
    end
  endtask

  task automatic run_case(string tag, input logic [1:0] m, input logic [63:0] n, input logic [63:0] d);
    logic [63:0] prev_r, eq, er, aq, ar;
    logic [15:0] c;
    logic ee;
    int n_busy;
    rd64(5'd13, prev_r);
    wr(5'd0, {14'd0, m});
    wr64(5'd1, n);
    wr64(5'd5, d);
    wait_busy(n_busy);
    ref_model(m, n, d, prev_r, eq, er, ee);
    rd64(5'd9, aq);
    rd64(5'd13, ar);
    rd16(5'd0, c);
    check("R7", {tag, " latency"}, 64'(n_busy), 64'(LAT));
    check(tag, "quotient", aq, eq);
    check(tag, "remainder", ar, er);
    check(tag, "error flag", 64'(c[14]), 64'(ee));
    check("R2", "mode readback", 64'(c[1:0]), 64'(m));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 17; a++) begin
      rd16(5'(a), v);
      check("R1", "reset value", 64'(v), 64'd0);
    end
  endtask

  task automatic t_ignored_writes();
    logic [63:0] q0, q1;
    logic [15:0] c, u;
    rd64(5'd9, q0);
    wr(5'd9, 16'hABCD);
    wr(5'd14, 16'h1234);
    wr(5'd20, 16'h5555);
    rd64(5'd9, q1);
    rd16(5'd0, c);
    rd16(5'd20, u);
    check("R2", "quotient after write", q1, q0);
    check("R2", "no start from result write", 64'(c[15]), 64'd0);
    check("R2", "unmapped read", 64'(u), 64'd0);
  endtask

  task automatic t_restart();
    logic [63:0] aq, ar;
    int n_busy;
    wr(5'd0, 16'd2);
    wr64(5'd1, 64'd1000);
    wr64(5'd5, 64'd7);
    repeat (LAT - 4) @(negedge clk);
    wr64(5'd5, 64'd3);
    wait_busy(n_busy);
    rd64(5'd9, aq);
    rd64(5'd13, ar);
    check("R8", "latency from latest write", 64'(n_busy), 64'(LAT));
    check("R8", "quotient of latest operands", aq, 64'd333);
    check("R8", "remainder of latest operands", ar, 64'd1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R4", 2'd2, 64'd7, 64'd2);
    run_case("R4", 2'd2, -64'sd7, 64'd2);
    run_case("R4", 2'd2, 64'd7, -64'sd2);
    run_case("R4", 2'd2, -64'sd7, -64'sd2);
    run_case("R4", 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd10);
    run_case("R3", 2'd0, 64'h1234_5678_FFFF_FF9C, 64'hDEAD_0000_0000_0007);
    run_case("R3", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0001_FFFF_FFFF);
    run_case("R3", 2'd1, 64'h0000_0010_0000_0000, 64'h0000_0005_FFFF_FFFE);
    run_case("R3", 2'd3, 64'hFFFF_FF00_0000_0001, 64'h7777_7777_0000_0100);
    run_case("R3", 2'd2, 64'h0000_0010_0000_0000, 64'h0000_0005_FFFF_FFFE);
    run_case("R5", 2'd2, -64'sd12345, 64'd0);
    run_case("R5", 2'd2, 64'd12345, 64'd0);
    run_case("R5", 2'd1, 64'd99, 64'hFFFF_FFFF_0000_0000);
    run_case("R6", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    run_case("R6", 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);
    run_case("R4", 2'd2, 64'd100, 64'd9);
    t_ignored_writes();
    t_restart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule